// File: doc/BRIEF.md
# Serial Transmitter with Selectable Empty Flag

This block serializes bytes written by a host onto an asynchronous serial line. A one-byte holding register accepts each write. A shift register then sends the character as a start bit, five to eight data bits with the least significant bit first, an optional parity bit, and one, one-and-a-half or two stop bits. Each bit lasts sixteen cycles of an oversampling tick enable, which a baud generator outside the block supplies. The block reports two status flags. The first says that the holding register can take a new byte. The second says that the transmitter is empty.

The mode input selects what "transmitter empty" means. In modern mode the flag is set only when both registers are empty, and it rises two ticks after the last stop bit ends. In legacy mode the flag follows the shift register alone: it rises in the tick where the shift register empties and falls when the shift register is reloaded. A break input holds the line low, and the framing logic keeps running underneath it. The line settings are captured when a byte moves into the shift register, so the host may change them for the next byte while the current byte is still being sent.

Top module: `uart_tx_temt`

## Requirements
- R1: A cycle with `wr_i` high loads `wr_data_i` into the holding register and drives both `thr_empty_o` and `tx_empty_o` to 0 from the next clock edge.
- R2: When the shift register is idle, the start bit begins in the tick that is the 16th tick after the write. `txd_o` is still 1 after the 15th such tick and is 0 after the 16th.
- R3: A frame is one start bit of 0, then `5 + wlen_i` data bits with the LSB first (`wlen_i` 00=5, 01=6, 10=7, 11=8), then a parity bit when `par_en_i` is 1. Each of these bits lasts 16 ticks. The parity bit makes the count of ones in the data and parity together even when `par_odd_i` is 0 and odd when `par_odd_i` is 1.
- R4: The stop period holds `txd_o` at 1. It lasts 16 ticks when `stop2_i` is 0. When `stop2_i` is 1 it lasts 32 ticks, or 24 ticks when `wlen_i` is 00.
- R5: `thr_empty_o` rises in the tick where the held byte moves to the shift register, and that same tick starts its start bit. If the holding register is full when a stop period ends, the next start bit begins in that tick and `tx_empty_o` stays 0.
- R6: With `legacy_i` = 0, `tx_empty_o` rises exactly 2 ticks after the stop period ends, and only if the holding register is empty at that point. While `tx_empty_o` is 1, `thr_empty_o` is also 1.
- R7: With `legacy_i` = 1, `tx_empty_o` rises in the tick where the stop period ends with no byte waiting, and it is cleared when the shift register is reloaded.
- R8: While `break_i` is 1, `txd_o` is 0. Frame timing and the flags continue exactly as they would without the break.
- R9: After reset, `txd_o`, `thr_empty_o` and `tx_empty_o` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversampling enable; 16 ticks per bit |
| wr_i | input | 1 | Write strobe for the holding register, one cycle per byte |
| wr_data_i | input | DW | Byte to send |
| wlen_i | input | 2 | Word length code (00=5 to 11=8 bits) |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop2_i | input | 1 | Long stop period (2 bits, or 1.5 bits for 5-bit words) |
| break_i | input | 1 | Forces the line low |
| legacy_i | input | 1 | Selects shift-register-only semantics for `tx_empty_o` |
| txd_o | output | 1 | Serial output, 1 when idle |
| thr_empty_o | output | 1 | Holding register is empty |
| tx_empty_o | output | 1 | Transmitter empty, with the meaning chosen by `legacy_i` |

## Verification
The assertions assume the following about the inputs: `wr_i` is a single-cycle strobe, the line settings stay constant between a write and the moment that byte moves to the shift register, and `legacy_i` changes only while both flags are 1. The stimulus follows these rules. It writes a byte only when the holding register is empty. It drives the write strobe only in cycles without a tick. It changes the mode and line settings only after a frame and its drain period have finished. Random bytes and settings run in both modes and are mixed with directed cases: back-to-back characters, the 1.5-stop-bit setting and a break held across the stop period.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_DRAIN
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } line_cfg_t;

  localparam int unsigned MIN_BITS = 5;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          busy_i,
  input  logic          stop_end_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          xfer_o
);
  localparam int unsigned LW = $clog2(OVS);
  localparam logic [LW-1:0] LEAD_LAST = LW'(OVS - 1);

  logic          full_q;
  logic [DW-1:0] data_q;
  logic [LW-1:0] lead_q;

  // idle shifter: wait one bit time before the start bit; busy shifter: hand over at stop end
  assign xfer_o = full_q && tick_i && (stop_end_i || (!busy_i && lead_q == LEAD_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      lead_q <= '0;
    end else begin
      if (wr_i) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (xfer_o) begin
        full_q <= 1'b0;
      end
      if (!full_q || busy_i || xfer_o) lead_q <= '0;
      else if (tick_i)                 lead_q <= lead_q + 1'b1;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned DRAIN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          xfer_i,
  input  logic [DW-1:0] data_i,
  input  line_cfg_t     cfg_i,
  output logic          line_o,
  output logic          busy_o,
  output logic          stop_end_o,
  output logic          drain_done_o
);
  localparam int unsigned SW = $clog2(2 * OVS);
  localparam int unsigned BW = $clog2(DW);
  localparam logic [SW-1:0] BIT_LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] STOP1    = SW'(OVS - 1);
  localparam logic [SW-1:0] STOP15   = SW'(OVS + OVS / 2 - 1);
  localparam logic [SW-1:0] STOP2    = SW'(2 * OVS - 1);
  localparam logic [SW-1:0] DR_LAST  = SW'(DRAIN - 1);

  tx_state_e     state_q;
  logic [SW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic [BW-1:0] bidx_q, blast_q;
  logic          par_q, par_en_q;
  logic [SW-1:0] stop_last_q;

  logic [DW-1:0] mask, masked;
  logic [BW-1:0] blast_d;
  logic [SW-1:0] stop_last_d;

  assign blast_d = BW'(MIN_BITS - 1) + BW'(cfg_i.wlen);

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (i <= int'(blast_d));
  end
  assign masked = data_i & mask;

  always_comb begin
    if (!cfg_i.stop2)          stop_last_d = STOP1;
    else if (cfg_i.wlen == '0) stop_last_d = STOP15;
    else                       stop_last_d = STOP2;
  end

  logic bit_end;
  assign bit_end      = tick_i && cnt_q == BIT_LAST;
  assign stop_end_o   = state_q == ST_STOP && tick_i && cnt_q == stop_last_q;
  assign drain_done_o = state_q == ST_DRAIN && tick_i && cnt_q == DR_LAST && !xfer_i;
  assign busy_o       = state_q inside {ST_START, ST_DATA, ST_PAR, ST_STOP};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      bidx_q      <= '0;
      blast_q     <= '0;
      par_q       <= 1'b0;
      par_en_q    <= 1'b0;
      stop_last_q <= '0;
    end else if (xfer_i) begin
      state_q     <= ST_START;
      cnt_q       <= '0;
      sh_q        <= masked;
      blast_q     <= blast_d;
      par_q       <= (^masked) ^ cfg_i.par_odd;
      par_en_q    <= cfg_i.par_en;
      stop_last_q <= stop_last_d;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_START: if (bit_end) begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
          bidx_q  <= '0;
        end
        ST_DATA: if (bit_end) begin
          cnt_q <= '0;
          sh_q  <= sh_q >> 1;
          if (bidx_q == blast_q) state_q <= par_en_q ? ST_PAR : ST_STOP;
          else                   bidx_q  <= bidx_q + 1'b1;
        end
        ST_PAR: if (bit_end) begin
          state_q <= ST_STOP;
          cnt_q   <= '0;
        end
        ST_STOP: if (cnt_q == stop_last_q) begin
          state_q <= ST_DRAIN;
          cnt_q   <= '0;
        end
        ST_DRAIN: if (cnt_q == DR_LAST) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic legacy_i,
  input  logic xfer_i,
  input  logic stop_end_i,
  input  logic drain_done_i,
  input  logic hold_full_i,
  output logic tx_empty_o
);
  logic temt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temt_q <= 1'b1;
    end else if (wr_i) begin
      temt_q <= 1'b0;
    end else if (legacy_i) begin
      if (xfer_i)          temt_q <= 1'b0;
      else if (stop_end_i) temt_q <= 1'b1;
    end else if (drain_done_i && !hold_full_i) begin
      temt_q <= 1'b1;
    end
  end

  assign tx_empty_o = temt_q;
endmodule

// File: rtl/uart_tx_temt.sv
module uart_tx_temt
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned DRAIN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    wlen_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          stop2_i,
  input  logic          break_i,
  input  logic          legacy_i,
  output logic          txd_o,
  output logic          thr_empty_o,
  output logic          tx_empty_o
);
  line_cfg_t     cfg;
  logic          hold_full, xfer, busy, stop_end, drain_done, line;
  logic [DW-1:0] hold_data;

  assign cfg = '{wlen: wlen_i, par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};

  uart_tx_hold #(.OVS(OVS), .DW(DW)) u_hold (
    .clk_i, .rst_ni, .tick_i(tick16_i), .wr_i, .wr_data_i,
    .busy_i(busy), .stop_end_i(stop_end),
    .full_o(hold_full), .data_o(hold_data), .xfer_o(xfer)
  );

  uart_tx_shift #(.OVS(OVS), .DW(DW), .DRAIN(DRAIN)) u_shift (
    .clk_i, .rst_ni, .tick_i(tick16_i), .xfer_i(xfer), .data_i(hold_data), .cfg_i(cfg),
    .line_o(line), .busy_o(busy), .stop_end_o(stop_end), .drain_done_o(drain_done)
  );

  uart_tx_status u_status (
    .clk_i, .rst_ni, .wr_i, .legacy_i, .xfer_i(xfer), .stop_end_i(stop_end),
    .drain_done_i(drain_done), .hold_full_i(hold_full), .tx_empty_o
  );

  assign txd_o       = line & ~break_i;
  assign thr_empty_o = ~hold_full;
endmodule

// File: rtl/uart_tx_temt_chk.sv
module uart_tx_temt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick16_i,
  input logic wr_i,
  input logic break_i,
  input logic legacy_i,
  input logic txd_o,
  input logic thr_empty_o,
  input logic tx_empty_o
);
  AST_WR_CLR_THRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !thr_empty_o); // R1
  AST_WR_CLR_TEMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !tx_empty_o); // R1
  AST_THRE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thr_empty_o) && !break_i |-> !txd_o); // R5
  AST_TEMT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy_i && tx_empty_o |-> thr_empty_o); // R6
  AST_TEMT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(tick16_i)); // R6
  AST_TEMT_LINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o && !break_i |-> txd_o); // R7
  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |-> !txd_o); // R8
endmodule

bind uart_tx_temt uart_tx_temt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick16_i(tick16_i), .wr_i(wr_i),
  .break_i(break_i), .legacy_i(legacy_i), .txd_o(txd_o),
  .thr_empty_o(thr_empty_o), .tx_empty_o(tx_empty_o)
);

// File: tb/uart_tx_temt_tb_top.sv
module uart_tx_temt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] wlen = '0;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, brk = 1'b0, legacy = 1'b0;
  logic       txd, thre, temt;
  int         checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  uart_tx_temt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .wlen_i(wlen), .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .break_i(brk), .legacy_i(legacy), .txd_o(txd), .thr_empty_o(thre), .tx_empty_o(temt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  function automatic bit exp_par(input logic [7:0] d, input int nb, input bit odd);
    bit p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic run(input logic [7:0] d, input logic [1:0] wl, input bit pe, input bit po,
                     input bit st2, input bit leg, input bit chain, input logic [7:0] d2,
                     input bit use_brk);
    int nb = 5 + int'(wl);
    int s  = st2 ? ((wl == 2'b00) ? 24 : 32) : 16;
    int ft = 16 * (1 + nb + int'(pe)) + s;
    int sb = 16 * (1 + nb + int'(pe));
    int nf = chain ? 2 : 1;
    legacy = leg; wlen = wl; par_en = pe; par_odd = po; stop2 = st2;
    do_write(d);
    chk(thre == 1'b0, "R1 thr_empty after write", thre, 0);
    chk(temt == 1'b0, "R1 tx_empty after write", temt, 0);
    for (int n = 1; n <= 16; n++) begin
      step();
      if (n == 15) chk(txd == 1'b1, "R2 line before start", txd, 1);
      if (n == 16) begin
        chk(txd == 1'b0, "R2 start bit at 16th tick", txd, 0);
        chk(thre == 1'b1, "R5 thr_empty at transfer", thre, 1);
      end
    end
    for (int f = 0; f < nf; f++) begin
      logic [7:0] cur = (f == 0) ? d : d2;
      bit brk_here = use_brk && (f == nf - 1);
      for (int t = 1; t <= ft; t++) begin
        if (chain && f == 0 && t == 4) begin
          do_write(d2);
          chk(thre == 1'b0, "R1 thr_empty after second write", thre, 0);
        end
        if (brk_here && t == sb + 2) brk = 1'b1;
        if (brk_here && t == ft - 2) brk = 1'b0;
        step();
        for (int j = 1; j <= nb; j++)
          if (t == 16 * j + 8) chk(txd == cur[j-1], "R3 data bit", txd, cur[j-1]);
        if (pe && t == 16 * (1 + nb) + 8)
          chk(txd == exp_par(cur, nb, po), "R3 parity bit", txd, exp_par(cur, nb, po));
        if (t == sb + 8) begin
          if (brk_here) chk(txd == 1'b0, "R8 break forces low", txd, 0);
          else          chk(txd == 1'b1, "R4 stop level", txd, 1);
        end
        if (t == ft - 1) begin
          chk(txd == 1'b1, "R4 stop still running", txd, 1);
          chk(temt == 1'b0, "R7 tx_empty before stop end", temt, 0);
        end
        if (t == ft) begin
          if (chain && f == 0) begin
            chk(txd == 1'b0, "R5 back-to-back start", txd, 0);
            chk(temt == 1'b0, "R5 tx_empty held low", temt, 0);
            chk(thre == 1'b1, "R5 thr_empty at reload", thre, 1);
          end else begin
            chk(txd == 1'b1, "R4 idle after stop", txd, 1);
            if (leg) chk(temt == 1'b1, "R7 legacy tx_empty at stop end", temt, 1);
            else     chk(temt == 1'b0, "R6 modern tx_empty delayed", temt, 0);
          end
        end
      end
    end
    step();
    if (!leg) chk(temt == 1'b0, "R6 tx_empty one tick after stop", temt, 0);
    step();
    chk(temt == 1'b1, "R6 tx_empty two ticks after stop", temt, 1);
    step();
    step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1bad5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R9 reset line", txd, 1);
    chk(thre == 1'b1, "R9 reset thr_empty", thre, 1);
    chk(temt == 1'b1, "R9 reset tx_empty", temt, 1);
    // directed corners
    run(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    run(8'h13, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0); // R4 1.5 stop
    run(8'h3C, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0); // R7
    run(8'hF0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0); // R5 chained
    run(8'h81, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h7E, 1'b0); // R5 legacy chained
    run(8'hFF, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1); // R8 break
    run(8'h00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1); // R8 legacy break
    for (int k = 0; k < 24; k++) begin
      logic [7:0] rd  = 8'($urandom);
      logic [7:0] rd2 = 8'($urandom);
      logic [1:0] rwl = 2'($urandom);
      logic [4:0] rb  = 5'($urandom);
      run(rd, rwl, rb[0], rb[1], rb[2], rb[3], rb[4], rd2, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule